// File: doc/BRIEF.md
# Multi-Channel Clock Frequency Supervisor

This block supervises up to eight external clock inputs from the system clock domain. Each input passes through a two-stage synchronizer, and its rising edges are detected there. For every enabled channel, the block counts those edges over a programmable window measured in system clock cycles. At the end of the window it compares the count with a shared pair of limits. A channel whose count falls below the lower limit or rises above the upper limit is reported as out of range. Each channel also reports that its measurement is complete.

Software drives the block over a simple register bus. Writes are single-cycle strobes, and read data is combinational on the address. Control, status and out-of-range registers are 16 bits wide, and each has one bit per channel. The per-channel result flags are cleared by writing one, and clearing a flag also restarts the measurement on that channel. Two summary flags follow the per-channel flags, and a level interrupt output follows the summary flags. The window length and both limits are latched when a measurement starts, so a new value applies from the next measurement. A window length of zero is treated as one cycle. Monitored clocks must run below half the system clock rate.

Top module: `clk_freq_supervisor`

## Requirements
- R1: After reset, every register reads zero and `irq_o` is low.
- R2: Bits 15:8 of the control (0x62), status (0x64) and out-of-range (0x66) registers always read zero, and writes to them have no effect.
- R3: Setting bit i of the control register (0x62) starts a measurement on channel i. Status bit i (0x64) stays clear during the window and is set within a few cycles after the window length (0x68, in system cycles) has elapsed.
- R4: When a measurement finishes, out-of-range bit i (0x66) is set if the count of rising edges is below the lower limit (0x6A) or above the upper limit (0x6C). A count inside the limits leaves the bit clear.
- R5: Writing 1 to status bit i clears only that bit and starts a new measurement on channel i. Writing 0 leaves the bit unchanged.
- R6: Writing 1 to out-of-range bit i clears only that bit and starts a new measurement on channel i, which sets the bit again if the count is still outside the limits.
- R7: A channel whose control bit is 0 never sets its status or out-of-range bit.
- R8: Summary register 0x6E bit 0 is set while any status bit is set, and bit 1 is set while any out-of-range bit is set. Both bits are write-one-to-clear. `irq_o` is high while either summary bit is set.
- R9: The window length (0x68), lower limit (0x6A) and upper limit (0x6C) registers read back the full 16-bit value last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mon_clk_i | input | NUM_CH | Monitored clock inputs, asynchronous |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Level interrupt, high while either summary bit is set |

## Verification
A wrong edge count or a wrong set of latched limits appears in the out-of-range register as soon as the window closes. The bench therefore drives every channel with a different known period and compares the whole flag vector against values worked out from the window length. A channel controller stuck busy, or one that ignores a restart, shows up as a status bit that never returns. A channel that restarts when it should not shows up as a bit that clears unexpectedly, within one window length of the write that caused it. A broken summary path shows up at `irq_o` one cycle after a per-channel flag changes.

// File: rtl/cfs_pkg.sv
package cfs_pkg;
  localparam int REG_W  = 16;
  localparam int ADDR_W = 8;
  localparam logic [ADDR_W-1:0] OFS_CTRL   = 8'h62;
  localparam logic [ADDR_W-1:0] OFS_STATUS = 8'h64;
  localparam logic [ADDR_W-1:0] OFS_OOR    = 8'h66;
  localparam logic [ADDR_W-1:0] OFS_WINDOW = 8'h68;
  localparam logic [ADDR_W-1:0] OFS_LOWER  = 8'h6A;
  localparam logic [ADDR_W-1:0] OFS_UPPER  = 8'h6C;
  localparam logic [ADDR_W-1:0] OFS_SUMM   = 8'h6E;
  localparam int SUMM_FIN = 0;
  localparam int SUMM_OOR = 1;
endpackage

// File: rtl/cfs_rst_sync.sv
module cfs_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) stage_q <= 2'b00;
    else          stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_o = stage_q[1];
endmodule

// File: rtl/cfs_edge_sync.sv
module cfs_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  logic [SYNC_STAGES:0] sh_q;
  logic [SYNC_STAGES:0] sh_d;

  always_comb sh_d = {sh_q[SYNC_STAGES-1:0], async_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rise_o = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];

  // R3: a detected rising edge lasts exactly one system cycle
  a_r3_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/cfs_channel.sv
module cfs_channel #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             restart_i,
  input  logic             edge_i,
  input  logic [CNT_W-1:0] window_i,
  input  logic [CNT_W-1:0] lower_i,
  input  logic [CNT_W-1:0] upper_i,
  output logic             done_o,
  output logic             oor_o
);
  logic             busy_q, busy_d;
  logic             en_q;
  logic [CNT_W-1:0] win_q, win_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] lo_q, lo_d;
  logic [CNT_W-1:0] hi_q, hi_d;
  logic [CNT_W-1:0] cnt_inc;
  logic             start, last;

  always_comb begin
    start   = en_i && (restart_i || !en_q);
    last    = busy_q && (win_q == CNT_W'(1));
    cnt_inc = (cnt_q == '1) ? cnt_q : cnt_q + CNT_W'(edge_i);
    done_o  = en_i && last && !restart_i;
    oor_o   = (cnt_inc < lo_q) || (cnt_inc > hi_q);
  end

  always_comb begin
    busy_d = busy_q;
    win_d  = win_q;
    cnt_d  = cnt_q;
    lo_d   = lo_q;
    hi_d   = hi_q;
    if (!en_i) begin
      busy_d = 1'b0;
      cnt_d  = '0;
    end else if (start) begin
      busy_d = 1'b1;
      win_d  = (window_i == '0) ? CNT_W'(1) : window_i;
      cnt_d  = '0;
      lo_d   = lower_i;
      hi_d   = upper_i;
    end else if (busy_q) begin
      cnt_d = cnt_inc;
      if (last) busy_d = 1'b0;
      else      win_d  = win_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      en_q   <= 1'b0;
      win_q  <= '0;
      cnt_q  <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
    end else begin
      busy_q <= busy_d;
      en_q   <= en_i;
      win_q  <= win_d;
      cnt_q  <= cnt_d;
      lo_q   <= lo_d;
      hi_q   <= hi_d;
    end
  end

  // R5: a restart on an enabled channel begins a fresh count
  a_r5_restart_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && restart_i) |=> (busy_q && cnt_q == '0));
  // R7: a disabled channel sits idle
  a_r7_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !busy_q);
endmodule

// File: rtl/cfs_regs.sv
module cfs_regs
  import cfs_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic [NUM_CH-1:0] ch_done_i,
  input  logic [NUM_CH-1:0] ch_oor_i,
  output logic [NUM_CH-1:0] ctrl_o,
  output logic [NUM_CH-1:0] restart_o,
  output logic [REG_W-1:0]  window_o,
  output logic [REG_W-1:0]  lower_o,
  output logic [REG_W-1:0]  upper_o,
  output logic              irq_o
);
  localparam int PAD_W = REG_W - NUM_CH;

  logic [NUM_CH-1:0] ctrl_q, ctrl_d;
  logic [NUM_CH-1:0] stat_q, stat_d;
  logic [NUM_CH-1:0] oor_q, oor_d;
  logic [1:0]        summ_q, summ_d;
  logic [REG_W-1:0]  win_q, win_d, lo_q, lo_d, hi_q, hi_d;
  logic [NUM_CH-1:0] stat_clr, oor_clr;
  logic [1:0]        summ_clr;

  always_comb begin
    stat_clr  = (bus_wr && bus_addr == OFS_STATUS) ? bus_wdata[NUM_CH-1:0] : '0;
    oor_clr   = (bus_wr && bus_addr == OFS_OOR)    ? bus_wdata[NUM_CH-1:0] : '0;
    summ_clr  = (bus_wr && bus_addr == OFS_SUMM)   ? bus_wdata[1:0]        : '0;
    restart_o = stat_clr | oor_clr;

    ctrl_d = (bus_wr && bus_addr == OFS_CTRL)   ? bus_wdata[NUM_CH-1:0] : ctrl_q;
    win_d  = (bus_wr && bus_addr == OFS_WINDOW) ? bus_wdata : win_q;
    lo_d   = (bus_wr && bus_addr == OFS_LOWER)  ? bus_wdata : lo_q;
    hi_d   = (bus_wr && bus_addr == OFS_UPPER)  ? bus_wdata : hi_q;

    stat_d = (stat_q & ~stat_clr) | ch_done_i;
    oor_d  = (oor_q  & ~oor_clr)  | (ch_done_i & ch_oor_i);
    summ_d = summ_q & ~summ_clr;
    if (|stat_q) summ_d[SUMM_FIN] = 1'b1;
    if (|oor_q)  summ_d[SUMM_OOR] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      stat_q <= '0;
      oor_q  <= '0;
      summ_q <= '0;
      win_q  <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      stat_q <= stat_d;
      oor_q  <= oor_d;
      summ_q <= summ_d;
      win_q  <= win_d;
      lo_q   <= lo_d;
      hi_q   <= hi_d;
    end
  end

  always_comb begin
    unique case (bus_addr)
      OFS_CTRL:   bus_rdata = {{PAD_W{1'b0}}, ctrl_q};
      OFS_STATUS: bus_rdata = {{PAD_W{1'b0}}, stat_q};
      OFS_OOR:    bus_rdata = {{PAD_W{1'b0}}, oor_q};
      OFS_WINDOW: bus_rdata = win_q;
      OFS_LOWER:  bus_rdata = lo_q;
      OFS_UPPER:  bus_rdata = hi_q;
      OFS_SUMM:   bus_rdata = {{(REG_W-2){1'b0}}, summ_q};
      default:    bus_rdata = '0;
    endcase
  end

  assign ctrl_o   = ctrl_q;
  assign window_o = win_q;
  assign lower_o  = lo_q;
  assign upper_o  = hi_q;
  assign irq_o    = |summ_q;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    // R7: a status flag only rises on an enabled channel
    a_r7_status_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_q[i]) |-> $past(ctrl_q[i]));
    // R4: an out-of-range flag only rises at the end of a measurement
    a_r4_oor_at_done: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(oor_q[i]) |-> $past(ch_done_i[i]));
  end

  // R8: any set status bit keeps the finished summary set
  a_r8_fin_summary: assert property (@(posedge clk) disable iff (!rst_n)
    (|stat_q) |=> summ_q[SUMM_FIN]);
  // R8: any set out-of-range bit keeps the range summary set
  a_r8_oor_summary: assert property (@(posedge clk) disable iff (!rst_n)
    (|oor_q) |=> summ_q[SUMM_OOR]);
  // R2: reserved upper bits of the flag registers read zero
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == OFS_CTRL || bus_addr == OFS_STATUS || bus_addr == OFS_OOR)
      |-> (bus_rdata[REG_W-1:NUM_CH] == '0));
endmodule

// File: rtl/clk_freq_supervisor.sv
module clk_freq_supervisor
  import cfs_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] mon_clk_i,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              irq_o
);
  logic              rst_n_s;
  logic [NUM_CH-1:0] rise, done, oor, ctrl, restart;
  logic [REG_W-1:0]  window, lower, upper;

  cfs_rst_sync u_rst (.clk(clk), .rst_n_i(rst_n), .rst_n_o(rst_n_s));

  cfs_regs #(.NUM_CH(NUM_CH)) u_regs (
    .clk(clk), .rst_n(rst_n_s),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .ch_done_i(done), .ch_oor_i(oor),
    .ctrl_o(ctrl), .restart_o(restart),
    .window_o(window), .lower_o(lower), .upper_o(upper),
    .irq_o(irq_o)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    cfs_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n_s), .async_i(mon_clk_i[i]), .rise_o(rise[i])
    );
    cfs_channel #(.CNT_W(REG_W)) u_ch (
      .clk(clk), .rst_n(rst_n_s),
      .en_i(ctrl[i]), .restart_i(restart[i]), .edge_i(rise[i]),
      .window_i(window), .lower_i(lower), .upper_i(upper),
      .done_o(done[i]), .oor_o(oor[i])
    );
  end
endmodule

// File: tb/clk_freq_supervisor_tb_top.sv
module clk_freq_supervisor_tb_top;
  localparam int NCH = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  mon;
  logic [7:0]  bus_addr;
  logic        bus_wr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        irq_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  clk_freq_supervisor #(.NUM_CH(NCH)) dut_i (
    .clk(clk), .rst_n(rst_n), .mon_clk_i(mon),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  // channel i toggles every i+2 system cycles: period 2*(i+2)
  int hcnt [NCH];
  initial begin
    mon = '0;
    for (int i = 0; i < NCH; i++) hcnt[i] = 0;
    forever begin
      @(negedge clk);
      for (int i = 0; i < NCH; i++) begin
        if (hcnt[i] == i + 1) begin
          hcnt[i] = 0;
          mon[i]  = ~mon[i];
        end else begin
          hcnt[i] = hcnt[i] + 1;
        end
      end
    end
  end

  // {window, lower, upper, expected out-of-range mask, pad}
  localparam logic [63:0] VEC [4] = '{
    {16'd720, 16'd55, 16'd100,   8'hE3, 8'h00},
    {16'd720, 16'd0,  16'hFFFF,  8'h00, 8'h00},
    {16'd720, 16'd65, 16'd95,    8'hF3, 8'h00},
    {16'd360, 16'd28, 16'd50,    8'hE3, 8'h00}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wait_bits(input logic [7:0] a, input logic [15:0] m,
                           input int limit, output logic [15:0] d);
    d = '0;
    for (int n = 0; n < limit; n++) begin
      rd(a, d);
      if ((d & m) == m) break;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] d;
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(8'h62, d); check("R1 ctrl", d, 16'h0);
    rd(8'h64, d); check("R1 status", d, 16'h0);
    rd(8'h66, d); check("R1 oor", d, 16'h0);
    rd(8'h6E, d); check("R1 summary", d, 16'h0);
    check("R1 irq_o", {15'b0, irq_o}, 16'h0);

    // R9 readback of window and limits
    wr(8'h68, 16'hA5C3); rd(8'h68, d); check("R9 window", d, 16'hA5C3);
    wr(8'h6A, 16'h3C5A); rd(8'h6A, d); check("R9 lower", d, 16'h3C5A);
    wr(8'h6C, 16'hFFFF); rd(8'h6C, d); check("R9 upper", d, 16'hFFFF);

    // R2 reserved bits ignore writes
    wr(8'h62, 16'hFF00); rd(8'h62, d); check("R2 ctrl reserved", d, 16'h0000);
    wr(8'h66, 16'hFF00); rd(8'h66, d); check("R2 oor reserved", d, 16'h0000);

    // R3 enable starts measurement, status arrives after the window
    wr(8'h68, 16'd720); wr(8'h6A, 16'd0); wr(8'h6C, 16'hFFFF);
    wr(8'h62, 16'hFFFF); rd(8'h62, d); check("R2 ctrl upper bits read zero", d, 16'h00FF);
    rd(8'h64, d); check("R3 status clear at start", d, 16'h0);
    repeat (300) @(negedge clk);
    rd(8'h64, d); check("R3 status clear mid-window", d, 16'h0);
    wait_bits(8'h64, 16'h00FF, 600, d); check("R3 status set after window", d, 16'h00FF);

    // R4 window compare over the vector table
    foreach (VEC[v]) begin
      wr(8'h68, VEC[v][63:48]);
      wr(8'h6A, VEC[v][47:32]);
      wr(8'h6C, VEC[v][31:16]);
      wr(8'h66, 16'h00FF);
      wr(8'h64, 16'h00FF);
      rd(8'h64, d); check("R5 status cleared by write", d, 16'h0);
      wait_bits(8'h64, 16'h00FF, 900, d); check("R5 status after restart", d, 16'h00FF);
      rd(8'h66, d); check("R4 out-of-range mask", d, {8'h00, VEC[v][15:8]});
    end

    // R5 single-channel clear
    wr(8'h64, 16'h0004); rd(8'h64, d); check("R5 one bit cleared", d, 16'h00FB);
    wait_bits(8'h64, 16'h0004, 600, d); check("R5 channel 2 re-measured", d, 16'h00FF);
    wr(8'h64, 16'h0000); rd(8'h64, d); check("R5 write zero keeps bits", d, 16'h00FF);

    // R6 out-of-range clear restarts and re-flags
    wr(8'h66, 16'h0001); rd(8'h66, d); check("R6 one oor bit cleared", d, 16'h00E2);
    wait_bits(8'h66, 16'h0001, 600, d); check("R6 oor re-flagged", d, 16'h00E3);

    // R7 disabled channel 7
    wr(8'h62, 16'h007F);
    wr(8'h66, 16'h00FF);
    wr(8'h64, 16'h00FF);
    wait_bits(8'h64, 16'h007F, 600, d);
    repeat (800) @(negedge clk);
    rd(8'h64, d); check("R7 status of disabled channel", d, 16'h007F);
    rd(8'h66, d); check("R7 oor of disabled channel", d & 16'h0080, 16'h0000);

    // R8 summary and interrupt
    rd(8'h6E, d); check("R8 summary set", d, 16'h0003);
    check("R8 irq_o high", {15'b0, irq_o}, 16'h1);
    wr(8'h6E, 16'h0003); rd(8'h6E, d); check("R8 summary re-sets while flags set", d, 16'h0003);
    wr(8'h62, 16'h0000);
    wr(8'h64, 16'h00FF);
    wr(8'h66, 16'h00FF);
    wr(8'h6E, 16'h0001); rd(8'h6E, d); check("R8 clear finished only", d, 16'h0002);
    check("R8 irq_o still high", {15'b0, irq_o}, 16'h1);
    wr(8'h6E, 16'h0002); rd(8'h6E, d); check("R8 summary cleared", d, 16'h0000);
    check("R8 irq_o low", {15'b0, irq_o}, 16'h0);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule